// File: doc/BRIEF.md
# UART Host Register Front-End with Byte Queues

This block is the host-facing register file of a 16550-style serial controller. A processor-side bus with a 3-bit offset, 8-bit write data and single-cycle read and write strobes reaches eight byte registers. Behind the data offset sit two 16-entry byte queues. The transmit queue is filled by host writes and emptied by a serial-side consumer through `tx_pop_i`. The receive queue is filled by a serial-side producer through `rx_push_i` and emptied by host reads.

Bit 7 of the line-control register switches offsets 0 and 1 between the data and interrupt-enable registers and the two halves of the baud divisor. The line-status register is not stored as written. It is built from queue events: arrivals, drains, overruns and flushes. Writes to the FIFO-control register can flush either queue or both. Baud generation, bit-level serialization and modem pins belong to neighbouring blocks.

Top module: `uart_regfront`

## Requirements
- R1: After reset, reads return: offset 1 = 0x03, offset 2 = 0xC0, offset 3 = 0x03, offset 4 = 0x00, offset 5 = 0x60, offset 6 = 0x00, offset 7 = 0x00. With offset 3 bit 7 set, offset 0 reads 0x01 and offset 1 reads 0x00.
- R2: With offset 3 bit 7 = 1, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. Writes to offset 0 then do not enter the transmit queue, and reads of offset 0 do not remove receive bytes. With bit 7 = 0, offset 0 is data and offset 1 is interrupt enable.
- R3: A write to offset 0 (bit 7 clear) appends the byte to a 16-entry transmit queue. `tx_valid_o` is high while the queue holds a byte, and `tx_data_o` shows the oldest byte. `tx_pop_i` removes that byte. A write while the queue holds 16 bytes is discarded.
- R4: Bytes presented with `rx_push_i` are read from offset 0 in arrival order, and each read removes one byte. A read of offset 0 with the receive queue empty returns 0x00 and changes nothing.
- R5: A byte pushed while the receive queue holds 16 bytes is discarded and sets line-status bit 1 (overrun).
- R6: A read of offset 5 returns the current line status, and bit 1 reads 0 afterwards. If an overrun happens in the same cycle, bit 1 stays 1.
- R7: Line-status bit 0 is 1 exactly while the receive queue is non-empty.
- R8: Line-status bits 5 and 6 are both 1 exactly while the transmit queue is empty, and both 0 otherwise. Bits 2, 3, 4 and 7 read 0.
- R9: A write to offset 2 with bit 0 = 1 stores the whole byte for readback. Bit 1 of that byte empties the receive queue, and bit 2 empties the transmit queue.
- R10: A write to offset 2 with bit 0 = 0 empties both queues and clears only bit 0 of the stored FIFO-control value.
- R11: Offsets 3, 4, 6 and 7 read back the last byte written to them. Writes to offset 5 have no effect.
- R12: A flush takes precedence over a push or pop to the same queue in the same cycle. The pushed byte is dropped and sets no overrun.
- R13: Full and empty are judged on the state before the cycle. A push to a full queue is discarded even when a pop happens in the same cycle, and a pop of an empty queue does nothing even when a push happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Host write data |
| wr_i | input | 1 | Host write strobe, one cycle per write |
| rd_i | input | 1 | Host read strobe; side effects take place at the end of the cycle |
| rdata_o | output | 8 | Read data for `addr_i`, valid in the cycle of `rd_i` |
| tx_data_o | output | 8 | Oldest byte of the transmit queue |
| tx_valid_o | output | 1 | Transmit queue non-empty |
| tx_pop_i | input | 1 | Serial side takes the oldest transmit byte |
| rx_data_i | input | 8 | Byte arriving from the serial side |
| rx_push_i | input | 1 | Serial side delivers `rx_data_i` |

## Verification
The serial side and the host side act in the same cycle. A serial-side arrival onto a full receive queue can coincide with a host data read, a line-status read or a FIFO-control flush. A host transmit write can coincide with a serial-side pop. Directed steps force each of these collisions at the full and empty boundaries. A long stretch of random traffic then mixes all of them. A queue-and-integer reference model applies the pre-cycle full/empty rule, flush precedence and overrun-over-clear priority, and every cycle is judged against it.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int RegW = 8;

  typedef enum logic [2:0] {
    OFF_DATA = 3'd0,
    OFF_IEN  = 3'd1,
    OFF_FCTL = 3'd2,
    OFF_LCTL = 3'd3,
    OFF_MCTL = 3'd4,
    OFF_LSTS = 3'd5,
    OFF_MSTS = 3'd6,
    OFF_SCR  = 3'd7
  } reg_off_e;

  localparam logic [7:0] IEN_RST  = 8'h03;
  localparam logic [7:0] FCTL_RST = 8'hC0;
  localparam logic [7:0] LCTL_RST = 8'h03;
  localparam logic [7:0] MCTL_RST = 8'h00;
  localparam logic [7:0] MSTS_RST = 8'h00;
  localparam logic [7:0] DIVL_RST = 8'h01;
  localparam logic [7:0] DIVH_RST = 8'h00;

  localparam int LctlBankBit = 7;
  localparam int FctlEnBit   = 0;
  localparam int FctlRxClr   = 1;
  localparam int FctlTxClr   = 2;

  typedef struct packed {
    logic [7:0] ien;
    logic [7:0] fctl;
    logic [7:0] lctl;
    logic [7:0] mctl;
    logic [7:0] msts;
    logic [7:0] scr;
    logic [7:0] divl;
    logic [7:0] divh;
  } ctl_regs_t;
endpackage

// File: rtl/uart_rf_fifo.sv
module uart_rf_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CW-1:0]    count_o,
  output logic             pushed_o,
  output logic             popped_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, rp_q, wp_nx, rp_nx;
  logic             full_q;

  assign empty_o  = (wp_q == rp_q) && !full_q;
  assign full_o   = full_q;
  assign pushed_o = push_i && !full_q && !flush_i;
  assign popped_o = pop_i && !empty_o && !flush_i;
  assign data_o   = mem_q[rp_q];
  assign count_o  = full_q ? CW'(DEPTH) : {1'b0, wp_q - rp_q};
  assign wp_nx    = wp_q + 1'b1;
  assign rp_nx    = rp_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      rp_q   <= '0;
      full_q <= 1'b0;
    end else if (flush_i) begin
      wp_q   <= '0;
      rp_q   <= '0;
      full_q <= 1'b0;
    end else begin
      if (pushed_o) wp_q <= wp_nx;
      if (popped_o) rp_q <= rp_nx;
      if (pushed_o && !popped_o && (wp_nx == rp_q)) full_q <= 1'b1;
      else if (popped_o && !pushed_o)               full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (pushed_o) mem_q[wp_q] <= data_i;
  end

  assert_count_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
  assert_full_drop_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_q && !flush_i) |=> (wp_q == $past(wp_q)));
  assert_flush_empties_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (empty_o && count_o == '0));
endmodule

// File: rtl/uart_rf_lsts.sv
module uart_rf_lsts #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_flush_i,
  input  logic          rx_pushed_i,
  input  logic          rx_popped_i,
  input  logic [CW-1:0] rx_count_i,
  input  logic          rx_overrun_i,
  input  logic          tx_flush_i,
  input  logic          tx_pushed_i,
  input  logic          tx_popped_i,
  input  logic [CW-1:0] tx_count_i,
  input  logic          lsts_rd_i,
  output logic [7:0]    lsts_o
);
  logic dr_q, oe_q, thre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dr_q   <= 1'b0;
      oe_q   <= 1'b0;
      thre_q <= 1'b1;
    end else begin
      if (rx_flush_i)                                           dr_q <= 1'b0;
      else if (rx_pushed_i)                                     dr_q <= 1'b1;
      else if (rx_popped_i && rx_count_i == CW'(1))             dr_q <= 1'b0;

      // a fresh overrun wins over the read-clear
      if (rx_overrun_i)   oe_q <= 1'b1;
      else if (lsts_rd_i) oe_q <= 1'b0;

      if (tx_flush_i)                                           thre_q <= 1'b1;
      else if (tx_pushed_i)                                     thre_q <= 1'b0;
      else if (tx_popped_i && tx_count_i == CW'(1))             thre_q <= 1'b1;
    end
  end

  assign lsts_o = {1'b0, thre_q, thre_q, 3'b000, oe_q, dr_q};
endmodule

// File: rtl/uart_rf_rdmux.sv
module uart_rf_rdmux
  import uart_rf_pkg::*;
(
  input  logic [2:0] addr_i,
  input  ctl_regs_t  regs_i,
  input  logic [7:0] lsts_i,
  input  logic [7:0] rx_head_i,
  input  logic       rx_empty_i,
  output logic [7:0] rdata_o
);
  logic bank;
  assign bank = regs_i.lctl[LctlBankBit];

  always_comb begin
    unique case (reg_off_e'(addr_i))
      OFF_DATA: rdata_o = bank ? regs_i.divl : (rx_empty_i ? 8'h00 : rx_head_i);
      OFF_IEN:  rdata_o = bank ? regs_i.divh : regs_i.ien;
      OFF_FCTL: rdata_o = regs_i.fctl;
      OFF_LCTL: rdata_o = regs_i.lctl;
      OFF_MCTL: rdata_o = regs_i.mctl;
      OFF_LSTS: rdata_o = lsts_i;
      OFF_MSTS: rdata_o = regs_i.msts;
      OFF_SCR:  rdata_o = regs_i.scr;
      default:  rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_rf_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CW = $clog2(FIFO_DEPTH) + 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       wr_i,
  input  logic       rd_i,
  output logic [7:0] rdata_o,
  output logic [7:0] tx_data_o,
  output logic       tx_valid_o,
  input  logic       tx_pop_i,
  input  logic [7:0] rx_data_i,
  input  logic       rx_push_i
);
  ctl_regs_t regs_q;
  logic [7:0] lsts;
  logic bank, wr_data, rd_data, wr_fctl, rx_flush, tx_flush, lsts_rd;
  logic rx_full, rx_empty, rx_pushed, rx_popped, rx_overrun;
  logic tx_full, tx_empty, tx_pushed, tx_popped;
  logic [CW-1:0] rx_count, tx_count;
  logic [7:0] rx_head;

  assign bank     = regs_q.lctl[LctlBankBit];
  assign wr_data  = wr_i && (addr_i == OFF_DATA) && !bank;
  assign rd_data  = rd_i && (addr_i == OFF_DATA) && !bank;
  assign wr_fctl  = wr_i && (addr_i == OFF_FCTL);
  assign rx_flush = wr_fctl && (!wdata_i[FctlEnBit] || wdata_i[FctlRxClr]);
  assign tx_flush = wr_fctl && (!wdata_i[FctlEnBit] || wdata_i[FctlTxClr]);
  assign lsts_rd  = rd_i && (addr_i == OFF_LSTS);
  assign rx_overrun = rx_push_i && rx_full && !rx_flush;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q.ien  <= IEN_RST;
      regs_q.fctl <= FCTL_RST;
      regs_q.lctl <= LCTL_RST;
      regs_q.mctl <= MCTL_RST;
      regs_q.msts <= MSTS_RST;
      regs_q.scr  <= 8'h00;
      regs_q.divl <= DIVL_RST;
      regs_q.divh <= DIVH_RST;
    end else if (wr_i) begin
      unique case (reg_off_e'(addr_i))
        OFF_DATA: if (bank) regs_q.divl <= wdata_i;
        OFF_IEN:  if (bank) regs_q.divh <= wdata_i;
                  else      regs_q.ien  <= wdata_i;
        OFF_FCTL: regs_q.fctl <= wdata_i[FctlEnBit] ? wdata_i
                                                    : {regs_q.fctl[7:1], 1'b0};
        OFF_LCTL: regs_q.lctl <= wdata_i;
        OFF_MCTL: regs_q.mctl <= wdata_i;
        OFF_LSTS: ;
        OFF_MSTS: regs_q.msts <= wdata_i;
        OFF_SCR:  regs_q.scr  <= wdata_i;
        default:  ;
      endcase
    end
  end

  uart_rf_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(RegW)) u_rx_fifo (
    .clk_i, .rst_ni,
    .flush_i (rx_flush),  .push_i (rx_push_i), .data_i (rx_data_i),
    .pop_i   (rd_data),   .data_o (rx_head),   .full_o (rx_full),
    .empty_o (rx_empty),  .count_o(rx_count),  .pushed_o(rx_pushed),
    .popped_o(rx_popped)
  );

  uart_rf_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(RegW)) u_tx_fifo (
    .clk_i, .rst_ni,
    .flush_i (tx_flush),  .push_i (wr_data),   .data_i (wdata_i),
    .pop_i   (tx_pop_i),  .data_o (tx_data_o), .full_o (tx_full),
    .empty_o (tx_empty),  .count_o(tx_count),  .pushed_o(tx_pushed),
    .popped_o(tx_popped)
  );

  uart_rf_lsts #(.CW(CW)) u_lsts (
    .clk_i, .rst_ni,
    .rx_flush_i (rx_flush),  .rx_pushed_i(rx_pushed), .rx_popped_i(rx_popped),
    .rx_count_i (rx_count),  .rx_overrun_i(rx_overrun),
    .tx_flush_i (tx_flush),  .tx_pushed_i(tx_pushed), .tx_popped_i(tx_popped),
    .tx_count_i (tx_count),  .lsts_rd_i  (lsts_rd),   .lsts_o     (lsts)
  );

  uart_rf_rdmux u_rdmux (
    .addr_i, .regs_i(regs_q), .lsts_i(lsts), .rx_head_i(rx_head),
    .rx_empty_i(rx_empty), .rdata_o
  );

  assign tx_valid_o = !tx_empty;

  assert_dr_tracks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsts[0] == (rx_count != '0));
  assert_thre_tracks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsts[5] == (tx_count == '0)) && (lsts[6] == lsts[5]));
  assert_overrun_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && rx_full && !rx_flush) |=> lsts[1]);
  assert_lsts_rd_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsts_rd && !(rx_push_i && rx_full)) |=> !lsts[1]);
  assert_bank_no_tx_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFF_DATA && bank && !tx_pop_i && !wr_fctl) |=> $stable(tx_count));
  assert_fctl_off_flush_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_fctl && !wdata_i[FctlEnBit]) |=> (rx_count == '0 && tx_count == '0));
endmodule

// File: tb/uart_regfront_tb.sv
module uart_regfront_tb;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rx_data_i = '0;
  logic wr_i = 0, rd_i = 0, tx_pop_i = 0, rx_push_i = 0;
  logic [7:0] rdata_o, tx_data_o;
  logic tx_valid_o;

  always #10 clk_i = ~clk_i;

  uart_regfront u_dut (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  string cur_req = "R1";

  logic [7:0] rxq[$], txq[$];
  logic [7:0] m_ien = 8'h03, m_fctl = 8'hC0, m_lctl = 8'h03, m_mctl = 8'h00;
  logic [7:0] m_msts = 8'h00, m_scr = 8'h00, m_divl = 8'h01, m_divh = 8'h00;
  bit m_oe = 0;

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(logic [2:0] a);
    bit bk = m_lctl[7];
    bit te = (txq.size() == 0);
    case (a)
      3'd0: return bk ? m_divl : (rxq.size() != 0 ? rxq[0] : 8'h00);
      3'd1: return bk ? m_divh : m_ien;
      3'd2: return m_fctl;
      3'd3: return m_lctl;
      3'd4: return m_mctl;
      3'd5: return {1'b0, te, te, 3'b000, m_oe, rxq.size() != 0};
      3'd6: return m_msts;
      default: return m_scr;
    endcase
  endfunction

  task automatic model_upd(logic [2:0] a, logic [7:0] w, bit wr, bit rd,
                           bit rp, logic [7:0] rb, bit tp);
    int rxn, txn;
    bit bk, rfl, tfl, ovr;
    rxn = rxq.size(); txn = txq.size(); bk = m_lctl[7];
    rfl = 0; tfl = 0; ovr = 0;
    if (wr && a == 3'd2) begin
      if (w[0]) begin rfl = w[1]; tfl = w[2]; end
      else begin rfl = 1; tfl = 1; end
    end
    if (rfl) rxq.delete();
    else begin
      if (rd && a == 3'd0 && !bk && rxn > 0) void'(rxq.pop_front());
      if (rp) begin
        if (rxn == 16) ovr = 1;
        else rxq.push_back(rb);
      end
    end
    if (tfl) txq.delete();
    else begin
      if (tp && txn > 0) void'(txq.pop_front());
      if (wr && a == 3'd0 && !bk && txn < 16) txq.push_back(w);
    end
    if (rd && a == 3'd5) m_oe = 0;
    if (ovr) m_oe = 1;
    if (wr) begin
      case (a)
        3'd0: if (bk) m_divl = w;
        3'd1: if (bk) m_divh = w; else m_ien = w;
        3'd2: m_fctl = w[0] ? w : {m_fctl[7:1], 1'b0};
        3'd3: m_lctl = w;
        3'd4: m_mctl = w;
        3'd6: m_msts = w;
        3'd7: m_scr = w;
        default: ;
      endcase
    end
  endtask

  // one bus cycle: drive at negedge, judge outputs, then advance the model past posedge
  task automatic step(logic [2:0] a, logic [7:0] w, bit wr, bit rd,
                      bit rp, logic [7:0] rb, bit tp);
    @(negedge clk_i);
    addr_i = a; wdata_i = w; wr_i = wr; rd_i = rd;
    rx_push_i = rp; rx_data_i = rb; tx_pop_i = tp;
    #1;
    if (rd) chk(cur_req, $sformatf("read off %0d", a), rdata_o, model_rd(a));
    chk(cur_req, "tx_valid", {7'd0, tx_valid_o}, {7'd0, txq.size() != 0});
    if (txq.size() != 0) chk(cur_req, "tx_data", tx_data_o, txq[0]);
    @(posedge clk_i);
    model_upd(a, w, wr, rd, rp, rb, tp);
  endtask

  task automatic hw(logic [2:0] a, logic [7:0] w); step(a, w, 1, 0, 0, 8'h00, 0); endtask
  task automatic hr(logic [2:0] a);                step(a, 8'h00, 0, 1, 0, 8'h00, 0); endtask
  task automatic rxp(logic [7:0] b);               step(3'd0, 8'h00, 0, 0, 1, b, 0); endtask
  task automatic txp();                            step(3'd0, 8'h00, 0, 0, 0, 8'h00, 1); endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    cur_req = "R1";
    for (int i = 0; i < 8; i++) hr(3'(i));
    hw(3'd3, 8'h83);
    hr(3'd0); hr(3'd1);

    cur_req = "R2";
    hw(3'd0, 8'h5A); hw(3'd1, 8'hA5);
    rxp(8'h11);
    hr(3'd0); hr(3'd1); hr(3'd5);
    hw(3'd3, 8'h03);
    hr(3'd0); hr(3'd1); hr(3'd0);
    hw(3'd1, 8'h0F); hr(3'd1);

    cur_req = "R11";
    hw(3'd4, 8'h1F); hw(3'd7, 8'hC3); hw(3'd6, 8'h99); hw(3'd5, 8'hFF);
    for (int i = 3; i < 8; i++) hr(3'(i));

    cur_req = "R3";
    for (int i = 0; i < 18; i++) hw(3'd0, 8'(8'h40 + i));
    cur_req = "R8";
    hr(3'd5);
    cur_req = "R3";
    for (int i = 0; i < 17; i++) txp();
    cur_req = "R8";
    hr(3'd5);

    cur_req = "R4";
    for (int i = 0; i < 5; i++) rxp(8'(8'hB0 + i));
    cur_req = "R7";
    hr(3'd5);
    cur_req = "R4";
    for (int i = 0; i < 6; i++) hr(3'd0);
    cur_req = "R7";
    hr(3'd5);

    cur_req = "R5";
    for (int i = 0; i < 17; i++) rxp(8'(i));
    hr(3'd5);
    cur_req = "R6";
    hr(3'd5);
    step(3'd5, 8'h00, 0, 1, 1, 8'hEE, 0);
    hr(3'd5); hr(3'd5);

    cur_req = "R13";
    step(3'd0, 8'h00, 0, 1, 1, 8'h77, 0);
    hr(3'd5);
    for (int i = 0; i < 16; i++) hw(3'd0, 8'(8'h60 + i));
    step(3'd0, 8'hF0, 1, 0, 0, 8'h00, 1);
    for (int i = 0; i < 16; i++) txp();
    step(3'd0, 8'h21, 1, 0, 0, 8'h00, 1);
    txp();

    cur_req = "R9";
    hw(3'd0, 8'hA1);
    hw(3'd2, 8'h03);
    hr(3'd0); hr(3'd2); hr(3'd5);
    hw(3'd2, 8'hC5);
    hr(3'd5); hr(3'd2);

    cur_req = "R10";
    rxp(8'h31); rxp(8'h32); hw(3'd0, 8'h33);
    hw(3'd2, 8'h40);
    hr(3'd2); hr(3'd5); hr(3'd0);

    cur_req = "R12";
    for (int i = 0; i < 16; i++) rxp(8'(8'h80 + i));
    step(3'd2, 8'h03, 1, 0, 1, 8'h99, 0);
    hr(3'd5);
    hw(3'd0, 8'h55);
    step(3'd2, 8'h05, 1, 0, 0, 8'h00, 1);
    hr(3'd5);

    cur_req = "R13";
    for (int i = 0; i < 400; i++) begin
      logic [2:0] a;
      logic [7:0] w;
      bit wr, rd;
      int op;
      op = $urandom_range(0, 19);
      wr = 0; rd = 0; a = 3'd0; w = 8'($urandom);
      if (op < 6) begin rd = 1; a = 3'd0; end
      else if (op < 12) begin wr = 1; a = 3'd0; end
      else if (op < 15) begin rd = 1; a = 3'd5; end
      else if (op == 15) begin wr = 1; a = 3'd2; end
      else if (op == 16) begin wr = 1; a = 3'd3; w = {w[0], 7'h03}; end
      else begin rd = 1; a = 3'($urandom_range(1, 7)); end
      step(a, w, wr, rd, $urandom_range(0, 2) != 0, 8'($urandom), $urandom_range(0, 2) == 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule